// File: doc/BRIEF.md
# Hashed Global-History Branch Direction Predictor

This block predicts whether a conditional branch will be taken, for the fetch stage of a small pipelined 8-bit CPU. It holds 1024 two-bit saturating counters. The fetch stage gives it a PC, and the prediction comes back combinationally in the same cycle. Because of that, the table is kept in flip-flops with an asynchronous read path, not in a clocked memory.

The table index has two parts. Five PC bits taken just above the two lowest bits pick an entry inside a 32-entry sub-table. Five bits of global history, XORed with the next five PC bits, pick which of the 32 sub-tables is used. The two lowest PC bits are not used, so branches a few bytes apart fall into one zone. PC bits above bit 11 are not used either.

The current global history is output with every prediction, and the pipeline carries it with the branch. When the branch resolves, the pipeline sends back the PC, that history snapshot and the outcome. The block then moves the counter selected by that index one step toward the outcome and shifts the outcome into the history.

Top module: `hist_hash_predictor`

## Requirements
- R1: While reset is low and after it is released, every counter holds 1 (weakly not-taken), so every PC predicts not-taken, and the history output is 0.
- R2: Index bits [9:5] are pc[6:2]; index bits [4:0] are history[5:1] XOR pc[11:7]. A change in any of these bits selects a different counter.
- R3: PC bits 1:0 and all PC bits above 11 have no effect on the index.
- R4: pred_taken_o is bit 1 of the counter selected by pred_pc_i and the current history, valid combinationally in the same cycle.
- R5: An update with upd_taken_i=1 increments the selected counter, which saturates at 3.
- R6: An update with upd_taken_i=0 decrements the selected counter, which saturates at 0.
- R7: On each update the history shifts left by one, with upd_taken_i entering at bit 0. Without an update the history holds. pred_hist_o shows the history value.
- R8: An update indexes the table with upd_hist_i and upd_pc_i, not with the current history.
- R9: A prediction and an update to the same counter in the same cycle return the counter value from before the update.
- R10: History bit 0 has no effect on the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pred_pc_i | input | 16 | Fetch PC to predict |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| pred_hist_o | output | 6 | Current global history, for the pipeline to carry |
| upd_valid_i | input | 1 | A resolved branch update is present |
| upd_pc_i | input | 16 | PC of the resolved branch |
| upd_hist_i | input | 6 | History snapshot taken when the branch was predicted |
| upd_taken_i | input | 1 | Resolved outcome, 1 = taken |

## Verification
A prediction is due in the same cycle as its PC. The bench drives inputs on the falling edge and samples pred_taken_o 1 ns later, before the next rising edge, and compares it with a behavioural table that has not yet taken that cycle's update. The effect of an update on a counter and on the history is due one rising edge later. The model applies the update right after that edge, so pred_hist_o and the later predictions are compared on the next falling-edge sample. The same-cycle case in R9 is covered because the model updates only after that sample.

// File: rtl/hhp_pkg.sv
package hhp_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_MAX  = 2'd3;
  localparam ctr_t CTR_MIN  = 2'd0;
  localparam ctr_t CTR_INIT = 2'd1;
endpackage

// File: rtl/hhp_index.sv
module hhp_index #(
  parameter int PC_W     = 16,
  parameter int HIST_W   = 6,
  parameter int ZONE_LSB = 2,
  parameter int ROW_BITS = 5,
  parameter int SEL_BITS = 5,
  parameter int HIST_LSB = 1,
  localparam int IDX_W   = ROW_BITS + SEL_BITS
) (
  input  logic [PC_W-1:0]   pc_i,
  input  logic [HIST_W-1:0] hist_i,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int SEL_PC_LSB = ZONE_LSB + ROW_BITS;

  logic [ROW_BITS-1:0] row;
  logic [SEL_BITS-1:0] sel;

  assign row   = pc_i[ZONE_LSB +: ROW_BITS];
  assign sel   = hist_i[HIST_LSB +: SEL_BITS] ^ pc_i[SEL_PC_LSB +: SEL_BITS];
  assign idx_o = {row, sel};
endmodule

// File: rtl/hhp_ctr_table.sv
module hhp_ctr_table
  import hhp_pkg::*;
#(
  parameter int IDX_W = 10,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_taken_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_taken_i
);
  ctr_t cnt_q [DEPTH];
  ctr_t wr_old;
  ctr_t wr_new;

  // async read: same-cycle prediction sees pre-update value
  assign rd_taken_o = cnt_q[rd_idx_i][1];
  assign wr_old     = cnt_q[wr_idx_i];

  always_comb begin
    wr_new = wr_old;
    if (wr_taken_i && wr_old != CTR_MAX)       wr_new = wr_old + 2'd1;
    else if (!wr_taken_i && wr_old != CTR_MIN) wr_new = wr_old - 2'd1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) cnt_q[i] <= CTR_INIT;
    end else if (wr_en_i) begin
      cnt_q[wr_idx_i] <= wr_new;
    end
  end

  a_r5_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_taken_i && wr_old != CTR_MAX |=>
      cnt_q[$past(wr_idx_i)] == $past(wr_old) + 2'd1);
  a_r5_sat_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_taken_i && wr_old == CTR_MAX |=> cnt_q[$past(wr_idx_i)] == CTR_MAX);
  a_r6_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !wr_taken_i && wr_old != CTR_MIN |=>
      cnt_q[$past(wr_idx_i)] == $past(wr_old) - 2'd1);
  a_r6_sat_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !wr_taken_i && wr_old == CTR_MIN |=> cnt_q[$past(wr_idx_i)] == CTR_MIN);
endmodule

// File: rtl/hhp_ghist.sv
module hhp_ghist #(
  parameter int HIST_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic              taken_i,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hist_q <= '0;
    else if (upd_i) hist_q <= {hist_q[HIST_W-2:0], taken_i};
  end

  assign hist_o = hist_q;

  a_r7_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> hist_q[0] == $past(taken_i) &&
              hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0]));
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(hist_q));
endmodule

// File: rtl/hist_hash_predictor.sv
module hist_hash_predictor #(
  parameter int PC_W     = 16,
  parameter int HIST_W   = 6,
  parameter int ZONE_LSB = 2,
  parameter int ROW_BITS = 5,
  parameter int SEL_BITS = 5,
  parameter int HIST_LSB = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PC_W-1:0]   pred_pc_i,
  output logic              pred_taken_o,
  output logic [HIST_W-1:0] pred_hist_o,
  input  logic              upd_valid_i,
  input  logic [PC_W-1:0]   upd_pc_i,
  input  logic [HIST_W-1:0] upd_hist_i,
  input  logic              upd_taken_i
);
  localparam int IDX_W = ROW_BITS + SEL_BITS;

  logic [HIST_W-1:0] ghist;
  logic [IDX_W-1:0]  rd_idx;
  logic [IDX_W-1:0]  wr_idx;

  hhp_index #(.PC_W(PC_W), .HIST_W(HIST_W), .ZONE_LSB(ZONE_LSB),
              .ROW_BITS(ROW_BITS), .SEL_BITS(SEL_BITS), .HIST_LSB(HIST_LSB))
    u_rd_index (.pc_i(pred_pc_i), .hist_i(ghist), .idx_o(rd_idx));

  hhp_index #(.PC_W(PC_W), .HIST_W(HIST_W), .ZONE_LSB(ZONE_LSB),
              .ROW_BITS(ROW_BITS), .SEL_BITS(SEL_BITS), .HIST_LSB(HIST_LSB))
    u_wr_index (.pc_i(upd_pc_i), .hist_i(upd_hist_i), .idx_o(wr_idx));

  hhp_ctr_table #(.IDX_W(IDX_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (rd_idx),
    .rd_taken_o (pred_taken_o),
    .wr_en_i    (upd_valid_i),
    .wr_idx_i   (wr_idx),
    .wr_taken_i (upd_taken_i)
  );

  hhp_ghist #(.HIST_W(HIST_W)) u_ghist (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upd_i   (upd_valid_i),
    .taken_i (upd_taken_i),
    .hist_o  (ghist)
  );

  assign pred_hist_o = ghist;
endmodule

// File: tb/hist_hash_predictor_test.sv
`timescale 1ns/1ps
module hist_hash_predictor_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] pred_pc_i = '0;
  logic        pred_taken_o;
  logic [5:0]  pred_hist_o;
  logic        upd_valid_i = 1'b0;
  logic [15:0] upd_pc_i = '0;
  logic [5:0]  upd_hist_i = '0;
  logic        upd_taken_i = 1'b0;

  hist_hash_predictor uut (.*);

  always #2.5 clk_i = ~clk_i;

  int errs = 0;
  int checks = 0;
  int mcnt [1024];
  int mh = 0;
  bit done = 0;

  // index: pc[6:2] on top, history[5:1]^pc[11:7] below
  function automatic int midx(int pc, int h);
    return ((pc >> 2) % 32) * 32 + ((((h >> 1) % 32) ^ ((pc >> 7) % 32)));
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(int pc, bit uv, int upc, int uh, bit ut, string tag);
    @(negedge clk_i);
    pred_pc_i   = 16'(pc);
    upd_valid_i = uv;
    upd_pc_i    = 16'(upc);
    upd_hist_i  = 6'(uh);
    upd_taken_i = ut;
    #1;
    check(tag, int'(pred_taken_o), (mcnt[midx(pc, mh)] >= 2) ? 1 : 0);
    check("R7", int'(pred_hist_o), mh);
    @(posedge clk_i);
    if (uv) begin
      int i = midx(upc, uh);
      if (ut && mcnt[i] < 3) mcnt[i]++;
      if (!ut && mcnt[i] > 0) mcnt[i]--;
      mh = ((mh << 1) | int'(ut)) % 64;
    end
  endtask

  task automatic expect_pred(int pc, int exp, string tag);
    @(negedge clk_i);
    pred_pc_i   = 16'(pc);
    upd_valid_i = 1'b0;
    #1;
    check(tag, int'(pred_taken_o), exp);
  endtask

  // drive the history to h through six updates at scratch pc 0
  task automatic set_hist(int h);
    for (int k = 5; k >= 0; k--) step(0, 1, 0, mh, bit'((h >> k) & 1), "R7");
  endtask

  localparam int P = 16'h0A54;
  int h;

  initial begin
    for (int i = 0; i < 1024; i++) mcnt[i] = 1;
    #1;
    check("R1", int'(pred_hist_o), 0);
    check("R1", int'(pred_taken_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    expect_pred(16'h1234, 0, "R1");
    expect_pred(16'hFFFF, 0, "R1");
    check("R1", int'(pred_hist_o), 0);

    set_hist(6'h2A);
    h = mh;
    // R8: second update arrives with a stale snapshot, current history differs
    step(P, 1, P, h, 1, "R4");
    step(P, 1, P, h, 1, "R8");
    set_hist(h);
    expect_pred(P, 1, "R8");
    expect_pred(P ^ 1, 1, "R3");
    expect_pred(P ^ 2, 1, "R3");
    expect_pred(P ^ 16'hF000, 1, "R3");
    expect_pred(P ^ 4, 0, "R2");
    expect_pred(P ^ 16'h0080, 0, "R2");
    set_hist(h ^ 1);
    expect_pred(P, 1, "R10");
    set_hist(h ^ 2);
    expect_pred(P, 0, "R2");

    // counter is 3: three more taken stay 3, one not-taken gives 2
    for (int k = 0; k < 3; k++) step(P ^ 4, 1, P, h, 1, "R5");
    step(P ^ 4, 1, P, h, 0, "R5");
    set_hist(h);
    expect_pred(P, 1, "R5");
    // 2 -> 0 and saturate, then one taken gives 1
    for (int k = 0; k < 4; k++) step(P ^ 4, 1, P, h, 0, "R6");
    step(P ^ 4, 1, P, h, 1, "R6");
    set_hist(h);
    expect_pred(P, 0, "R6");
    step(P ^ 4, 1, P, h, 1, "R6");
    set_hist(h);
    expect_pred(P, 1, "R5");
    // R9: counter 2, same-cycle predict and not-taken update
    step(P, 1, P, h, 0, "R9");
    set_hist(h);
    expect_pred(P, 0, "R9");

    for (int n = 0; n < 600; n++) begin
      int pcs [4] = '{P, P ^ 16'h0080, 16'h0104, 16'h3F7C};
      int pp = pcs[$urandom_range(3)] ^ int'($urandom_range(3));
      int up = pcs[$urandom_range(3)];
      step(pp, bit'($urandom_range(1)), up, int'($urandom_range(63)),
           bit'($urandom_range(1)), "R4");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk_i);
        checks++;
        errs++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule